// File: doc/BRIEF.md
# Dual-Timer Count Source Selector

This block holds two up-counting timers, timer A and timer B. Each advances on a count event taken from one of four sources. The source for each timer is chosen by a 2-bit field in one shared 8-bit control register. The four sources are:

- the timer prescaler tick;
- an external pin;
- a CPU activity strobe;
- the peripheral prescaler tick.

The CPU activity source differs between the two timers. Timer A counts executed instructions. Timer B counts ROM bytes fetched, so it can advance by up to three in a single clock.

The external pins are treated as asynchronous. They are synchronized and edge-detected before they are counted. When a timer wraps, a sticky overflow flag is set, and software clears it by writing a one to it. Changing a source takes effect on the next clock, and the value already counted is kept.

The block is used next to a clock-prescaler unit and a CPU core. Those supply the strobes, and software uses the write port to pick the sources.

Top module: `dual_src_timer`

## Requirements
- R1: While `rst_n` is low, both timer values, both overflow flags and the whole control register are zero. Both source selects are therefore 2'b00.
- R2: Timer A's source select is `ctl_q[5:4]`. The codes are: 00 = `tmr_tick`, 01 = rising edges of `ext_pin0`, 10 = `instr_req`, 11 = `per_tick`. Each selected event adds one, and sources that are not selected have no effect.
- R3: Timer B's source select is `ctl_q[7:6]`. The codes are: 00 = `tmr_tick`, 01 = rising edges of `ext_pin1`, 10 = ROM requests, 11 = `per_tick`. Sources that are not selected have no effect.
- R4: A write with `wr_en`=1 and `wr_addr`=0 loads `wr_data` into the control register, which is visible on `ctl_q` after that clock. Bits [3:0] read back as written and change no counting.
- R5: Each external pin passes through a two-flop synchronizer. The timer adds exactly one per rising edge of the pin, however long the pin stays high. A pin that rises before clock edge k is counted at edge k+2, so the value changes on `tmr*_q` after the third edge.
- R6: With Timer B's select at 10, a cycle with `rom_req`=1 adds `rom_bytes` (values 1 to 3) to Timer B in that one clock.
- R7: With Timer A's select at 10, each cycle with `instr_req`=1 adds one to Timer A.
- R8: A timer whose sum passes 16'hFFFF wraps modulo 2^16 and sets its overflow flag. The flag stays set until it is cleared.
- R9: A write with `wr_addr`=1 clears the Timer A flag where `wr_data[0]`=1 and the Timer B flag where `wr_data[1]`=1. An overflow in the same cycle wins over the clear.
- R10: A change of a source select is used from the clock after the write. The clock that performs the write still counts with the old source, and the count value is kept across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_tick | input | 1 | Timer prescaler tick, one-cycle strobe |
| per_tick | input | 1 | Peripheral prescaler tick, one-cycle strobe |
| ext_pin0 | input | 1 | Asynchronous external count pin for Timer A |
| ext_pin1 | input | 1 | Asynchronous external count pin for Timer B |
| instr_req | input | 1 | One strobe per executed instruction |
| rom_req | input | 1 | ROM request strobe |
| rom_bytes | input | 2 | Bytes fetched by the current ROM request |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | 0 = control register, 1 = overflow clear |
| wr_data | input | 8 | Write data |
| ctl_q | output | 8 | Control register contents |
| tmr0_q | output | 16 | Timer A value |
| tmr1_q | output | 16 | Timer B value |
| ovf0_q | output | 1 | Timer A sticky overflow flag |
| ovf1_q | output | 1 | Timer B sticky overflow flag |

## Verification
Every select code is run with random strobes on all sources at the same time. If a timer tracks only the strobes of its own selected source, a swapped code or a leak from an unselected source shows up.

Pin tests cover:
- single-cycle pulses and long high levels, which separate edge counting from level counting;
- a rise followed clock by clock, which pins down the synchronizer latency.

ROM requests with fixed byte counts of 1 and 3 drive Timer B up to and across the wrap. This tells multi-byte adds apart from single increments and checks the wrapped value. A clear that lands on the wrapping cycle shows which of the two has priority.

// File: rtl/dual_src_timer.sv
module dual_src_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_tick,
  input  logic         per_tick,
  input  logic         ext_pin0,
  input  logic         ext_pin1,
  input  logic         instr_req,
  input  logic         rom_req,
  input  logic [1:0]   rom_bytes,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [7:0]   wr_data,
  output logic [7:0]   ctl_q,
  output logic [W-1:0] tmr0_q,
  output logic [W-1:0] tmr1_q,
  output logic         ovf0_q,
  output logic         ovf1_q
);

  logic [2:0]   sync0, sync1;
  logic [W-1:0] inc0, inc1;
  logic [W:0]   sum0, sum1;

  wire edge0  = sync0[1] & ~sync0[2];
  wire edge1  = sync1[1] & ~sync1[2];
  wire ctl_we = wr_en & ~wr_addr;
  wire clr_we = wr_en & wr_addr;

  always_comb begin
    case (ctl_q[5:4])
      2'b00:   inc0 = W'(tmr_tick);
      2'b01:   inc0 = W'(edge0);
      2'b10:   inc0 = W'(instr_req);
      default: inc0 = W'(per_tick);
    endcase
    case (ctl_q[7:6])
      2'b00:   inc1 = W'(tmr_tick);
      2'b01:   inc1 = W'(edge1);
      2'b10:   inc1 = rom_req ? W'(rom_bytes) : '0;
      default: inc1 = W'(per_tick);
    endcase
  end

  assign sum0 = {1'b0, tmr0_q} + {1'b0, inc0};
  assign sum1 = {1'b0, tmr1_q} + {1'b0, inc1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0  <= '0;
      sync1  <= '0;
      ctl_q  <= '0;
      tmr0_q <= '0;
      tmr1_q <= '0;
      ovf0_q <= 1'b0;
      ovf1_q <= 1'b0;
    end else begin
      sync0  <= {sync0[1:0], ext_pin0};
      sync1  <= {sync1[1:0], ext_pin1};
      tmr0_q <= sum0[W-1:0];
      tmr1_q <= sum1[W-1:0];
      ovf0_q <= sum0[W] | (ovf0_q & ~(clr_we & wr_data[0]));
      ovf1_q <= sum1[W] | (ovf1_q & ~(clr_we & wr_data[1]));
      if (ctl_we) ctl_q <= wr_data;
    end
  end

endmodule

module dual_src_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         instr_req,
  input logic         rom_req,
  input logic [1:0]   rom_bytes,
  input logic         wr_en,
  input logic         wr_addr,
  input logic [7:0]   wr_data,
  input logic [7:0]   ctl_q,
  input logic [W-1:0] tmr0_q,
  input logic [W-1:0] tmr1_q,
  input logic         ovf0_q,
  input logic         ovf1_q
);

  always @(negedge clk)
    if (!rst_n)
      a_r1_reset_state: assert (tmr0_q == '0 && tmr1_q == '0 && !ovf0_q && !ovf1_q && ctl_q == 8'h00);

  a_r7_instr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[5:4] == 2'b10) |=> tmr0_q == W'($past(tmr0_q) + W'($past(instr_req))));

  a_r6_rom_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[7:6] == 2'b10) |=>
      tmr1_q == W'($past(tmr1_q) + ($past(rom_req) ? W'($past(rom_bytes)) : W'(0))));

  a_r5_pin_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[5:4] == 2'b01) |=> W'(tmr0_q - $past(tmr0_q)) <= W'(1));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf0_q && !(wr_en && wr_addr && wr_data[0])) |=> ovf0_q);

  a_r9_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && wr_data[1] && ctl_q[7:6] == 2'b00) |=> !ovf1_q || tmr1_q == '0);

endmodule

bind dual_src_timer dual_src_timer_chk #(.W(W)) u_chk (.*);

// File: tb/dual_src_timer_test.sv
module dual_src_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tmr_tick = 0, per_tick = 0, ext_pin0 = 0, ext_pin1 = 0;
  logic instr_req = 0, rom_req = 0, wr_en = 0, wr_addr = 0;
  logic [1:0] rom_bytes = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctl_q;
  logic [15:0] tmr0_q, tmr1_q;
  logic ovf0_q, ovf1_q;

  int checks = 0, errors = 0;
  string cur = "R1";

  dual_src_timer uut (.*);

  always #2 clk = ~clk;

  // behavioural reference model
  int m_t0, m_t1;
  bit m_o0, m_o1;
  bit [7:0] m_ctl;
  bit h0[$], h1[$];

  always @(posedge clk or negedge rst_n) begin
    int i0, i1;
    bit v0, v1, e0, e1;
    if (!rst_n) begin
      m_t0 = 0; m_t1 = 0; m_o0 = 0; m_o1 = 0; m_ctl = 0;
      h0 = '{0, 0, 0}; h1 = '{0, 0, 0};
    end else begin
      e0 = h0[1] && !h0[2];
      e1 = h1[1] && !h1[2];
      case (m_ctl[5:4])
        0: i0 = int'(tmr_tick);
        1: i0 = int'(e0);
        2: i0 = int'(instr_req);
        default: i0 = int'(per_tick);
      endcase
      case (m_ctl[7:6])
        0: i1 = int'(tmr_tick);
        1: i1 = int'(e1);
        2: i1 = rom_req ? int'(rom_bytes) : 0;
        default: i1 = int'(per_tick);
      endcase
      h0.push_front(ext_pin0); void'(h0.pop_back());
      h1.push_front(ext_pin1); void'(h1.pop_back());
      m_t0 += i0; v0 = m_t0 > 65535; m_t0 %= 65536;
      m_t1 += i1; v1 = m_t1 > 65535; m_t1 %= 65536;
      if (wr_en && wr_addr && wr_data[0]) m_o0 = 0;
      if (wr_en && wr_addr && wr_data[1]) m_o1 = 0;
      if (v0) m_o0 = 1;
      if (v1) m_o1 = 1;
      if (wr_en && !wr_addr) m_ctl = wr_data;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur, "model tmr0", int'(tmr0_q), m_t0);
    chk(cur, "model tmr1", int'(tmr1_q), m_t1);
    chk(cur, "model ovf0", int'(ovf0_q), int'(m_o0));
    chk(cur, "model ovf1", int'(ovf1_q), int'(m_o1));
    chk(cur, "model ctl", int'(ctl_q), int'(m_ctl));
  end

  task automatic quiet();
    tmr_tick = 0; per_tick = 0; instr_req = 0; rom_req = 0; rom_bytes = 0;
  endtask

  task automatic wr(bit a, bit [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", cur);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0, a1, n0, n1, need;
    bit p;
    repeat (3) @(negedge clk);
    cur = "R1";
    chk("R1", "reset tmr0", int'(tmr0_q), 0);
    chk("R1", "reset tmr1", int'(tmr1_q), 0);
    chk("R1", "reset flags", int'({ovf0_q, ovf1_q}), 0);
    chk("R1", "reset ctl", int'(ctl_q), 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3 select 00: only tmr_tick counts
    cur = "R2";
    a0 = tmr0_q; a1 = tmr1_q; n0 = 0;
    for (int i = 0; i < 40; i++) begin
      tmr_tick = 1'($urandom); per_tick = 1'($urandom); instr_req = 1'($urandom);
      rom_req = 1'($urandom); rom_bytes = 2'd3;
      ext_pin0 = 1'($urandom); ext_pin1 = 1'($urandom);
      n0 += int'(tmr_tick);
      @(negedge clk);
    end
    quiet(); ext_pin0 = 0; ext_pin1 = 0;
    @(negedge clk);
    chk("R2", "sel00 tmr0", int'(tmr0_q), (a0 + n0) % 65536);
    chk("R3", "sel00 tmr1", int'(tmr1_q), (a1 + n0) % 65536);

    // R10: switch to 11 during a per_tick cycle
    cur = "R10";
    a0 = tmr0_q; a1 = tmr1_q;
    per_tick = 1;
    wr(0, 8'b1111_0101);
    chk("R10", "write cycle keeps tmr0", int'(tmr0_q), a0);
    chk("R4", "ctl readback", int'(ctl_q), 8'hF5);
    @(negedge clk);
    chk("R10", "new select next clock", int'(tmr0_q), (a0 + 1) % 65536);
    chk("R10", "new select next clock b", int'(tmr1_q), (a1 + 1) % 65536);

    // R2/R3 select 11, and R4 low bits have no effect
    cur = "R4";
    a0 = tmr0_q; n0 = 0;
    for (int i = 0; i < 40; i++) begin
      tmr_tick = 1'($urandom); per_tick = 1'($urandom); instr_req = 1'($urandom);
      if (i == 20) wr_data = 8'b1111_1010;
      wr_en = (i == 20); wr_addr = 0;
      n0 += int'(per_tick);
      @(negedge clk);
    end
    wr_en = 0; quiet();
    @(negedge clk);
    chk("R4", "low bits readback", int'(ctl_q), 8'hFA);
    chk("R2", "sel11 tmr0", int'(tmr0_q), (a0 + n0) % 65536);

    // R6/R7 CPU activity sources
    cur = "R7";
    wr(0, 8'b1010_0000);
    a0 = tmr0_q; a1 = tmr1_q; n0 = 0; n1 = 0;
    for (int i = 0; i < 60; i++) begin
      instr_req = 1'($urandom); rom_req = 1'($urandom);
      rom_bytes = 2'(1 + ($urandom % 3)); tmr_tick = 1'($urandom); per_tick = 1'($urandom);
      n0 += int'(instr_req);
      if (rom_req) n1 += int'(rom_bytes);
      @(negedge clk);
    end
    quiet();
    @(negedge clk);
    chk("R7", "instr count", int'(tmr0_q), (a0 + n0) % 65536);
    chk("R6", "rom byte sum", int'(tmr1_q), (a1 + n1) % 65536);

    // R5 pins
    cur = "R5";
    wr(0, 8'b0101_0000);
    repeat (4) @(negedge clk);
    a0 = tmr0_q;
    ext_pin0 = 1;
    @(negedge clk); @(negedge clk);
    chk("R5", "no count before sync", int'(tmr0_q), a0);
    @(negedge clk);
    chk("R5", "count after third edge", int'(tmr0_q), (a0 + 1) % 65536);
    repeat (6) @(negedge clk);
    chk("R5", "long high counts once", int'(tmr0_q), (a0 + 1) % 65536);
    ext_pin0 = 0;
    @(negedge clk);
    a0 = tmr0_q; a1 = tmr1_q; n0 = 0; n1 = 0;
    for (int i = 0; i < 80; i++) begin
      p = 1'($urandom);
      if (p && !ext_pin0) n0++;
      ext_pin0 = p;
      p = (i % 5 == 0);
      if (p && !ext_pin1) n1++;
      ext_pin1 = p;
      tmr_tick = 1'($urandom); per_tick = 1'($urandom); instr_req = 1'($urandom);
      @(negedge clk);
    end
    ext_pin0 = 0; ext_pin1 = 0; quiet();
    repeat (4) @(negedge clk);
    chk("R5", "pin0 edges", int'(tmr0_q), (a0 + n0) % 65536);
    chk("R5", "pin1 pulses", int'(tmr1_q), (a1 + n1) % 65536);

    // R8 wrap on timer B through ROM bytes of 3
    cur = "R8";
    wr(0, 8'b1011_0000);
    a0 = tmr0_q; a1 = tmr1_q;
    rom_req = 1; rom_bytes = 3; per_tick = 1;
    repeat (22000) @(negedge clk);
    quiet();
    repeat (3) @(negedge clk);
    chk("R8", "tmr1 wrapped value", int'(tmr1_q), (a1 + 66000) % 65536);
    chk("R8", "ovf1 set", int'(ovf1_q), 1);
    chk("R8", "tmr0 per_tick value", int'(tmr0_q), (a0 + 22000) % 65536);
    per_tick = 1;
    repeat (65536 - 22000) @(negedge clk);
    per_tick = 0;
    @(negedge clk);
    chk("R8", "tmr0 full turn", int'(tmr0_q), a0);
    chk("R8", "ovf0 set", int'(ovf0_q), 1);
    repeat (5) @(negedge clk);
    chk("R8", "ovf1 sticky", int'(ovf1_q), 1);

    // R9 clears
    cur = "R9";
    wr(1, 8'b0000_0001);
    chk("R9", "ovf0 cleared", int'(ovf0_q), 0);
    chk("R9", "ovf1 kept", int'(ovf1_q), 1);
    need = 65535 - int'(tmr1_q);
    rom_req = 1;
    rom_bytes = 3; repeat (need / 3) @(negedge clk);
    rom_bytes = 1; repeat (need % 3) @(negedge clk);
    chk("R9", "tmr1 at top", int'(tmr1_q), 65535);
    wr_en = 1; wr_addr = 1; wr_data = 8'b0000_0010;
    @(negedge clk);
    wr_en = 0; wr_data = 0; quiet();
    chk("R9", "set wins over clear", int'(ovf1_q), 1);
    chk("R8", "wrap to zero", int'(tmr1_q), 0);
    wr(1, 8'b0000_0010);
    chk("R9", "ovf1 cleared", int'(ovf1_q), 0);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule